// File: doc/BRIEF.md
# Pointer-Based Synchronous Queue with Occupancy Flags

This block is a single-clock first-in-first-out queue. It lets a producer and a consumer that run at unrelated rates share a buffer. A typical case is a processor that writes samples in bursts while a converter drains them at a steady rate. Both sides see full, empty and half-full status, and each side paces itself on those flags.

Two pointers address a dual-port storage array. The write pointer names the slot that the next accepted write fills. The read pointer names the slot that the next accepted read takes. Both pointers have exactly the address width and wrap modulo the depth. When the pointers are equal, the queue is either full or empty. A single flag records whether the last operation that moved only one pointer was a write or a read, and that flag settles which case applies. The queue needs no extra pointer bit and no count register.

Read data is registered. The word taken by an accepted read appears on the output one cycle after the read, and it holds until the next accepted read.

Top module: `ptr_fifo`

## Requirements
- R1: While reset is asserted and right after it is released, empty is 1, full is 0, half_full is 0 and rd_data is 0.
- R2: Words leave in the order they were accepted. The word for an accepted read is on rd_data after the next rising clock edge, and rd_data does not change in a cycle without an accepted read.
- R3: After DEPTH accepted writes with no reads in between, starting from empty, full is 1 and empty is 0.
- R4: When an accepted read takes the last stored word, empty becomes 1 and full is 0.
- R5: A write request while full is dropped. The flags stay the same and the stored contents are unchanged.
- R6: A read request while empty is dropped. empty stays 1 and rd_data holds its value.
- R7: When a read and a write are both requested while the queue is neither full nor empty, both are accepted, the occupancy is unchanged and all three flags keep their values.
- R8: half_full is 1 exactly when the occupancy is at least DEPTH/2, and that includes the full state.
- R9: Both pointers wrap modulo DEPTH (a power of two), and order is preserved across any number of wraps.
- R10: A simultaneous read and write while full accepts only the read. While empty, the same pair accepts only the write.
- R11: full and empty are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| full | output | 1 | No free slot |
| empty | output | 1 | No stored word |
| half_full | output | 1 | Occupancy is at least DEPTH/2 |

## Verification
The assertions assume that wr_en and rd_en are known at every edge after reset. They also assume the producer and consumer may raise requests against a full or empty queue at any time, so every request pattern is legal and none needs a guard. The stimulus covers fills past full, drains past empty and paired requests at both extremes. It then runs a long stretch of random request pairs, which moves the pointers through many wraps.

// File: rtl/ptr_fifo_pkg.sv
package ptr_fifo_pkg;

  // Which single-pointer operation happened last; resolves pointer equality.
  typedef enum logic {
    LAST_RD = 1'b0,
    LAST_WR = 1'b1
  } last_op_e;

endpackage

// File: rtl/ptr_fifo_ptr.sv
// Address pointer that advances by one on enable and wraps modulo 2**ADDR_W.
module ptr_fifo_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) begin
      ptr_d = ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/ptr_fifo_mem.sv
// Dual-port array: one write port, one read port with a registered output.
module ptr_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_d;

  // The storage array has no reset; a slot is only read after it was written.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (re) begin
      rdata_d = store[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/ptr_fifo_status.sv
// Last-operation flag and the full, empty and half-full decode.
module ptr_fifo_status
  import ptr_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  logic [ADDR_W-1:0] wptr,
  input  logic [ADDR_W-1:0] rptr,
  output logic              full,
  output logic              empty,
  output logic              half_full
);

  localparam int OCC_W = ADDR_W + 1;
  localparam logic [OCC_W-1:0] HALF_LVL = OCC_W'(DEPTH / 2);
  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);

  last_op_e          last_q;
  last_op_e          last_d;
  logic              ptr_eq;
  logic [ADDR_W-1:0] ptr_gap;
  logic [OCC_W-1:0]  occ;

  // The flag only moves when exactly one pointer advances.
  always_comb begin
    last_d = last_q;
    if (wr_acc && !rd_acc) begin
      last_d = LAST_WR;
    end else if (rd_acc && !wr_acc) begin
      last_d = LAST_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_RD;
    end else if (wr_acc != rd_acc) begin
      last_q <= last_d;
    end
  end

  always_comb begin
    ptr_eq  = (wptr == rptr);
    ptr_gap = wptr - rptr;
    full    = ptr_eq && (last_q == LAST_WR);
    empty   = ptr_eq && (last_q == LAST_RD);
    occ     = full ? FULL_LVL : {1'b0, ptr_gap};
    half_full = (occ >= HALF_LVL);
  end

endmodule

// File: rtl/ptr_fifo.sv
// Single-clock queue: two wrapping pointers over a dual-port array.
module ptr_fifo
  import ptr_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              half_full
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              wr_acc;
  logic              rd_acc;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0] rptr;

  // Requests against a full or empty queue are dropped here.
  always_comb begin
    wr_acc = wr_en && !full;
    rd_acc = rd_en && !empty;
  end

  ptr_fifo_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (wr_acc),
    .ptr  (wptr)
  );

  ptr_fifo_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (rd_acc),
    .ptr  (rptr)
  );

  ptr_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_acc),
    .waddr(wptr),
    .wdata(wr_data),
    .re   (rd_acc),
    .raddr(rptr),
    .rdata(rd_data)
  );

  ptr_fifo_status #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .wptr     (wptr),
    .rptr     (rptr),
    .full     (full),
    .empty    (empty),
    .half_full(half_full)
  );

endmodule

// File: rtl/ptr_fifo_chk.sv
// Port-level checker for ptr_fifo, attached by bind.
module ptr_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              full,
  input logic              empty,
  input logic              half_full
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  // Shadow occupancy counter kept from the request pins.
  logic [CW-1:0] occ_q;
  logic          w_ok;
  logic          r_ok;

  always_comb begin
    w_ok = wr_en && (occ_q != CW'(DEPTH));
    r_ok = rd_en && (occ_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (w_ok && !r_ok) begin
      occ_q <= occ_q + CW'(1);
    end else if (r_ok && !w_ok) begin
      occ_q <= occ_q - CW'(1);
    end
  end

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r3_full_from_count: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ_q == CW'(DEPTH)));

  a_r4_empty_from_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (occ_q == '0));

  a_r8_half_level: assert property (@(posedge clk) disable iff (!rst_n)
    half_full == (occ_q >= CW'(DEPTH / 2)));

  a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && $stable(rd_data)));

  a_r6_empty_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !empty) |=> $stable(rd_data));

  a_r7_paired_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && wr_en && rd_en) |=>
      ($stable(full) && $stable(empty) && $stable(half_full)));

  a_r10_paired_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rd_en) |=> !full);

  a_r10_paired_at_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_en && rd_en) |=> !empty);

endmodule

bind ptr_fifo ptr_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .full     (full),
  .empty    (empty),
  .half_full(half_full)
);

// File: tb/ptr_fifo_tb_top.sv
module ptr_fifo_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              rd_en;
  logic [DATA_W-1:0] rd_data;
  logic              full;
  logic              empty;
  logic              half_full;

  int n_chk;
  int n_fail;
  bit done;

  // Reference model state
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] exp_rd;
  logic [DATA_W-1:0] next_word;

  ptr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .full     (full),
    .empty    (empty),
    .half_full(half_full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    int sz;
    sz = q.size();
    check(tag, "full",  32'(full),  32'(sz == DEPTH));
    check(tag, "empty", 32'(empty), 32'(sz == 0));
    check("R8", "half_full", 32'(half_full), 32'(sz >= DEPTH / 2));
    check("R11", "full&empty", 32'(full && empty), 32'd0);
    check("R2", "rd_data", 32'(rd_data), 32'(exp_rd));
  endtask

  // Called at a falling edge: drive, let one rising edge pass, update model, compare.
  task automatic step(input logic w, input logic r, input string tag);
    bit acc_w;
    bit acc_r;
    wr_en   = w;
    rd_en   = r;
    wr_data = next_word;
    acc_w   = w && (q.size() < DEPTH);
    acc_r   = r && (q.size() > 0);
    @(posedge clk);
    if (acc_r) exp_rd = q.pop_front();
    if (acc_w) begin
      q.push_back(next_word);
      next_word = next_word + 8'd1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    compare_all(tag);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    exp_rd = '0;
    next_word = 8'h10;
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "empty", 32'(empty), 32'd1);
    check("R1", "full", 32'(full), 32'd0);
    check("R1", "half_full", 32'(half_full), 32'd0);
    check("R1", "rd_data", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R6: reads against an empty queue
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R6");

    // R3: fill to the top (half_full crossing is R8)
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, "R3");

    // R5: writes while full are dropped
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5");

    // R10: paired request at full takes only the read
    step(1'b1, 1'b1, "R10");
    step(1'b1, 1'b0, "R10");

    // R4: drain past empty
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, "R4");

    // R10: paired request at empty takes only the write
    step(1'b1, 1'b1, "R10");

    // R7: paired traffic at mid occupancy
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, "R7");

    // R8: walk occupancy up through the half level and back
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R8");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R8");

    // R9: random traffic, many pointer wraps
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] rnd;
      rnd = 2'($urandom_range(0, 3));
      step(rnd[0], rnd[1], "R9");
    end

    // R9: final drain keeps order
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule